// File: doc/BRIEF.md
# Dual Quad-SPI Flash Topology Router

This block joins one quad-SPI master port to two identical serial flash devices, so that together they look like a single flash reached through one logical chip select. A 32-bit configuration word picks the wiring. The choices are a single device, two devices sharing one bus with a page bit choosing which one is enabled, or two devices on separate 4-bit buses that each hold half of every data byte. The master supplies one chip select, one clock and an 8-bit wide IO path. The router creates the second device's chip select itself, and it steers, splits or merges the data.

The routing is purely combinational from the master port to the device ports. The only state is the configuration register. A new configuration word is never allowed to change the topology while a transfer is in progress. A word written during a transfer waits until the master's chip select goes high, and is then applied.

In the two-bus mode a phase input from the master separates command and address cycles from data cycles. During command and address cycles the master's low nibble is copied to both buses unchanged. During data cycles a full byte is spread across both buses, one bit at a time.

Top module: `qspi_dual_router`

## Requirements
- R1: The configuration word uses bit 30 as the two-device enable, bit 29 as the separate-bus select and bit 28 as the upper-page select. All other bits have no effect. After reset all three fields are clear, which means single-device operation on the lower device.
- R2: With the two-device enable clear, the lower device receives m_cs_n, m_sclk, m_io_o[3:0] and m_io_oe[3:0]. The upper device sees up_cs_n=1, up_sclk=0, up_io_o=0 and up_io_oe=0. m_io_i is {4'b0, lo_io_i}. The separate-bus bit alone has no effect.
- R3: In stacked mode (enable=1, separate-bus=0), both buses carry m_io_o[3:0] and m_io_oe[3:0], and both clocks follow m_sclk. m_cs_n goes to the lower device when the upper-page bit is 0 and to the upper device when it is 1. The chip select of the other device stays high.
- R4: In stacked mode, m_io_i[3:0] comes from the selected device's input bus and m_io_i[7:4] is 0.
- R5: In parallel mode (enable=1, separate-bus=1), lo_cs_n and up_cs_n both equal m_cs_n, and both clocks follow m_sclk.
- R6: In parallel mode with m_data_phase=0, both buses carry m_io_o[3:0] and m_io_oe[3:0], and m_io_i is {4'b0, lo_io_i}.
- R7: In parallel mode with m_data_phase=1, for each lane k: lo_io_o[k]=m_io_o[2k] and up_io_o[k]=m_io_o[2k+1]. The output enables are split the same way.
- R8: In parallel mode with m_data_phase=1, for each lane k: m_io_i[2k]=lo_io_i[k] and m_io_i[2k+1]=up_io_i[k].
- R9: A configuration write made while m_cs_n=1 takes effect at that clock edge. A write made while m_cs_n=0 is held and is applied at the first clock edge where m_cs_n=1. A later write replaces a held one.
- R10: m_data_phase has no effect outside parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| m_cs_n | input | 1 | Master chip select, active low |
| m_sclk | input | 1 | Master serial clock |
| m_data_phase | input | 1 | High during data cycles |
| m_io_o | input | 8 | Master output data |
| m_io_oe | input | 8 | Master per-bit output enables |
| m_io_i | output | 8 | Read data returned to the master |
| lo_cs_n | output | 1 | Lower device chip select |
| lo_sclk | output | 1 | Lower device clock |
| lo_io_o | output | 4 | Lower device output data |
| lo_io_oe | output | 4 | Lower device output enables |
| lo_io_i | input | 4 | Lower device read data |
| up_cs_n | output | 1 | Upper device chip select |
| up_sclk | output | 1 | Upper device clock |
| up_io_o | output | 4 | Upper device output data |
| up_io_oe | output | 4 | Upper device output enables |
| up_io_i | input | 4 | Upper device read data |

## Verification
The hardest situation to reach is a configuration write that arrives while a transfer is active, in particular when a second write replaces the held one before the chip select rises. The random stimulus keeps m_cs_n low most of the time and issues writes with random words. This builds up held writes, overwrites and releases in many orders. A directed sequence also forces the overwrite case and checks routing both before and after the release. Other directed cases use upper-device read data that differs from the lower device's, so a wrong page steer or a wrong interleave shows up as a changed m_io_i.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    localparam int CFG_W      = 32;
    localparam int DUAL_BIT   = 30;
    localparam int SEPBUS_BIT = 29;
    localparam int UPAGE_BIT  = 28;

    typedef enum logic [1:0] {
        TOPO_SINGLE   = 2'd0,
        TOPO_STACKED  = 2'd1,
        TOPO_PARALLEL = 2'd2
    } topo_e;

    typedef struct packed {
        logic dual;
        logic sepbus;
        logic upage;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{dual: 1'b0, sepbus: 1'b0, upage: 1'b0};

    function automatic cfg_t cfg_from_word(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.dual   = w[DUAL_BIT];
        c.sepbus = w[SEPBUS_BIT];
        c.upage  = w[UPAGE_BIT];
        return c;
    endfunction

    function automatic topo_e topo_of(input cfg_t c);
        if (!c.dual)
            return TOPO_SINGLE;
        if (!c.sepbus)
            return TOPO_STACKED;
        return TOPO_PARALLEL;
    endfunction

endpackage

// File: rtl/qdr_cfg_reg.sv
module qdr_cfg_reg
    import qdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer_idle,
    output cfg_t             act_cfg
);

    cfg_t act_q;
    cfg_t pend_q;
    logic pend_v;

    // A write is held while a transfer runs, and is released at the first idle edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= CFG_RESET;
            pend_q <= CFG_RESET;
            pend_v <= 1'b0;
        end else if (cfg_wr && xfer_idle) begin
            act_q  <= cfg_from_word(cfg_wdata);
            pend_v <= 1'b0;
        end else if (cfg_wr) begin
            pend_q <= cfg_from_word(cfg_wdata);
            pend_v <= 1'b1;
        end else if (pend_v && xfer_idle) begin
            act_q  <= pend_q;
            pend_v <= 1'b0;
        end
    end

    assign act_cfg = act_q;

    // R9: the topology never changes across an edge sampled mid-transfer
    a_r9_no_change_mid_xfer: assert property (@(posedge clk) disable iff (rst)
        !xfer_idle |=> $stable(act_q));

    // R9: a held word is released at the first idle edge
    a_r9_pending_released: assert property (@(posedge clk) disable iff (rst)
        (pend_v && xfer_idle) |=> !pend_v);

endmodule

// File: rtl/qdr_cs_steer.sv
module qdr_cs_steer
    import qdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  topo_e topo,
    input  logic  upage,
    input  logic  m_cs_n,
    input  logic  m_sclk,
    output logic  lo_cs_n,
    output logic  up_cs_n,
    output logic  lo_sclk,
    output logic  up_sclk
);

    logic upper_only;
    logic upper_used;

    assign upper_only = (topo == TOPO_STACKED) && upage;
    assign upper_used = (topo == TOPO_PARALLEL) || upper_only;

    assign lo_cs_n = upper_only ? 1'b1 : m_cs_n;
    assign up_cs_n = upper_used ? m_cs_n : 1'b1;
    assign lo_sclk = m_sclk;
    assign up_sclk = (topo == TOPO_SINGLE) ? 1'b0 : m_sclk;

    // R3: in stacked mode at most one device is selected
    a_r3_one_device_selected: assert property (@(posedge clk) disable iff (rst)
        (topo == TOPO_STACKED) |-> (lo_cs_n || up_cs_n));

    // R5: in parallel mode both devices are selected together
    a_r5_cs_together: assert property (@(posedge clk) disable iff (rst)
        (topo == TOPO_PARALLEL) |-> (lo_cs_n == up_cs_n));

    // R2: in single mode the upper device is never selected or clocked
    a_r2_upper_idle: assert property (@(posedge clk) disable iff (rst)
        (topo == TOPO_SINGLE) |-> (up_cs_n && !up_sclk));

endmodule

// File: rtl/qdr_lane_mux.sv
module qdr_lane_mux
    import qdr_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  topo_e              topo,
    input  logic               upage,
    input  logic               data_phase,
    input  logic [2*LANES-1:0] m_io_o,
    input  logic [2*LANES-1:0] m_io_oe,
    output logic [2*LANES-1:0] m_io_i,
    output logic [LANES-1:0]   lo_io_o,
    output logic [LANES-1:0]   lo_io_oe,
    input  logic [LANES-1:0]   lo_io_i,
    output logic [LANES-1:0]   up_io_o,
    output logic [LANES-1:0]   up_io_oe,
    input  logic [LANES-1:0]   up_io_i
);

    localparam int BUS_W = 2 * LANES;

    logic             weave;
    logic             up_on;
    logic [LANES-1:0] sel_i;
    logic [BUS_W-1:0] woven;
    logic [BUS_W-1:0] narrow;

    assign weave = (topo == TOPO_PARALLEL) && data_phase;
    assign up_on = (topo != TOPO_SINGLE);
    assign sel_i = ((topo == TOPO_STACKED) && upage) ? up_io_i : lo_io_i;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lo_io_o[k]  = weave ? m_io_o[2*k]  : m_io_o[k];
        assign lo_io_oe[k] = weave ? m_io_oe[2*k] : m_io_oe[k];
        assign up_io_o[k]  = up_on & (weave ? m_io_o[2*k+1]  : m_io_o[k]);
        assign up_io_oe[k] = up_on & (weave ? m_io_oe[2*k+1] : m_io_oe[k]);

        assign woven[2*k]     = lo_io_i[k];
        assign woven[2*k+1]   = up_io_i[k];
        assign narrow[k]       = sel_i[k];
        assign narrow[k+LANES] = 1'b0;
    end

    assign m_io_i = weave ? woven : narrow;

    // R2: the upper bus stays quiet when only one device is fitted
    a_r2_upper_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        (topo == TOPO_SINGLE) |-> (up_io_oe == '0 && up_io_o == '0));

    // R6: command and address cycles put identical values on both buses
    a_r6_cmd_copied: assert property (@(posedge clk) disable iff (rst)
        ((topo == TOPO_PARALLEL) && !data_phase) |-> (lo_io_o == up_io_o && lo_io_oe == up_io_oe));

    // R4: the upper half of the return path is zero when not interleaving
    a_r4_high_nibble_zero: assert property (@(posedge clk) disable iff (rst)
        !weave |-> (m_io_i[BUS_W-1:LANES] == '0));

endmodule

// File: rtl/qspi_dual_router.sv
module qspi_dual_router
    import qdr_pkg::*;
#(
    parameter int LANES = 4,
    localparam int BUS_W = 2 * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             m_cs_n,
    input  logic             m_sclk,
    input  logic             m_data_phase,
    input  logic [BUS_W-1:0] m_io_o,
    input  logic [BUS_W-1:0] m_io_oe,
    output logic [BUS_W-1:0] m_io_i,
    output logic             lo_cs_n,
    output logic             lo_sclk,
    output logic [LANES-1:0] lo_io_o,
    output logic [LANES-1:0] lo_io_oe,
    input  logic [LANES-1:0] lo_io_i,
    output logic             up_cs_n,
    output logic             up_sclk,
    output logic [LANES-1:0] up_io_o,
    output logic [LANES-1:0] up_io_oe,
    input  logic [LANES-1:0] up_io_i
);

    cfg_t  act_cfg;
    topo_e topo;

    qdr_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .xfer_idle (m_cs_n),
        .act_cfg   (act_cfg)
    );

    assign topo = topo_of(act_cfg);

    qdr_cs_steer u_cs (
        .clk     (clk),
        .rst     (rst),
        .topo    (topo),
        .upage   (act_cfg.upage),
        .m_cs_n  (m_cs_n),
        .m_sclk  (m_sclk),
        .lo_cs_n (lo_cs_n),
        .up_cs_n (up_cs_n),
        .lo_sclk (lo_sclk),
        .up_sclk (up_sclk)
    );

    qdr_lane_mux #(.LANES(LANES)) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .topo       (topo),
        .upage      (act_cfg.upage),
        .data_phase (m_data_phase),
        .m_io_o     (m_io_o),
        .m_io_oe    (m_io_oe),
        .m_io_i     (m_io_i),
        .lo_io_o    (lo_io_o),
        .lo_io_oe   (lo_io_oe),
        .lo_io_i    (lo_io_i),
        .up_io_o    (up_io_o),
        .up_io_oe   (up_io_oe),
        .up_io_i    (up_io_i)
    );

endmodule

// File: tb/sim_qspi_dual_router.sv
module sim_qspi_dual_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        m_cs_n = 1'b1;
    logic        m_sclk = 1'b0;
    logic        m_data_phase = 1'b0;
    logic [7:0]  m_io_o = '0;
    logic [7:0]  m_io_oe = '0;
    logic [7:0]  m_io_i;
    logic        lo_cs_n, lo_sclk, up_cs_n, up_sclk;
    logic [3:0]  lo_io_o, lo_io_oe, up_io_o, up_io_oe;
    logic [3:0]  lo_io_i = '0;
    logic [3:0]  up_io_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state: {dual, sepbus, upage}
    logic [2:0] mdl_cfg = 3'b000;
    logic [2:0] mdl_pend = 3'b000;
    logic       mdl_pv = 1'b0;

    always #2 clk = ~clk;

    qspi_dual_router u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .m_cs_n(m_cs_n), .m_sclk(m_sclk), .m_data_phase(m_data_phase),
        .m_io_o(m_io_o), .m_io_oe(m_io_oe), .m_io_i(m_io_i),
        .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk), .lo_io_o(lo_io_o),
        .lo_io_oe(lo_io_oe), .lo_io_i(lo_io_i),
        .up_cs_n(up_cs_n), .up_sclk(up_sclk), .up_io_o(up_io_o),
        .up_io_oe(up_io_oe), .up_io_i(up_io_i)
    );

    function automatic logic [2:0] fields(input logic [31:0] w);
        return {w[30], w[29], w[28]};
    endfunction

    function automatic logic [3:0] pick(input logic [7:0] b, input int ofs);
        return {b[6+ofs], b[4+ofs], b[2+ofs], b[ofs]};
    endfunction

    // expected {lo_cs, lo_sclk, lo_o, lo_oe, up_cs, up_sclk, up_o, up_oe, m_i}
    function automatic logic [27:0] expect_out(input logic [2:0] c);
        logic lcs, lck, ucs, uck;
        logic [3:0] lo, loe, uo, uoe;
        logic [7:0] mi;
        lck = m_sclk;
        if (!c[2]) begin
            lcs = m_cs_n; lo = m_io_o[3:0]; loe = m_io_oe[3:0];
            ucs = 1'b1; uck = 1'b0; uo = '0; uoe = '0;
            mi = {4'b0, lo_io_i};
        end else if (!c[1]) begin
            lcs = c[0] ? 1'b1 : m_cs_n;
            ucs = c[0] ? m_cs_n : 1'b1;
            uck = m_sclk;
            lo = m_io_o[3:0]; loe = m_io_oe[3:0];
            uo = m_io_o[3:0]; uoe = m_io_oe[3:0];
            mi = {4'b0, c[0] ? up_io_i : lo_io_i};
        end else begin
            lcs = m_cs_n; ucs = m_cs_n; uck = m_sclk;
            if (m_data_phase) begin
                lo = pick(m_io_o, 0); uo = pick(m_io_o, 1);
                loe = pick(m_io_oe, 0); uoe = pick(m_io_oe, 1);
                for (int k = 0; k < 4; k++) begin
                    mi[2*k]   = lo_io_i[k];
                    mi[2*k+1] = up_io_i[k];
                end
            end else begin
                lo = m_io_o[3:0]; loe = m_io_oe[3:0];
                uo = m_io_o[3:0]; uoe = m_io_oe[3:0];
                mi = {4'b0, lo_io_i};
            end
        end
        return {lcs, lck, lo, loe, ucs, uck, uo, uoe, mi};
    endfunction

    task automatic check(input string tag);
        logic [27:0] act, exp;
        act = {lo_cs_n, lo_sclk, lo_io_o, lo_io_oe, up_cs_n, up_sclk, up_io_o, up_io_oe, m_io_i};
        exp = expect_out(mdl_cfg);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (cfg %b)", tag, act, exp, mdl_cfg);
        end
    endtask

    // caller sets inputs at the falling edge; check, then let the rising edge update the model
    task automatic tick(input string tag, input bit do_check);
        #1;
        if (do_check) check(tag);
        @(posedge clk);
        if (rst) begin
            mdl_cfg = 3'b000; mdl_pv = 1'b0;
        end else if (cfg_wr && m_cs_n) begin
            mdl_cfg = fields(cfg_wdata); mdl_pv = 1'b0;
        end else if (cfg_wr) begin
            mdl_pend = fields(cfg_wdata); mdl_pv = 1'b1;
        end else if (mdl_pv && m_cs_n) begin
            mdl_cfg = mdl_pend; mdl_pv = 1'b0;
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_cfg(input logic [31:0] w, input string tag);
        cfg_wr = 1'b1; cfg_wdata = w;
        tick(tag, 1'b1);
    endtask

    task automatic drive(input logic cs, input logic dp, input logic [7:0] o,
                         input logic [7:0] oe, input logic [3:0] li, input logic [3:0] ui);
        m_cs_n = cs; m_data_phase = dp; m_io_o = o; m_io_oe = oe;
        lo_io_i = li; up_io_i = ui;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        string tag;
        void'($urandom(32'h5EED_0C0A));
        @(negedge clk);
        tick("R1", 1'b0);
        tick("R1", 1'b1);                       // R1: reset state is single lower
        rst = 1'b0;
        drive(1'b0, 1'b0, 8'hA5, 8'h3C, 4'h9, 4'h6);
        tick("R1", 1'b1);

        // R2: separate-bus bit alone leaves single mode; other bits ignored (R1)
        drive(1'b1, 1'b0, 8'h5A, 8'hFF, 4'h3, 4'hC);
        wr_cfg(32'hA000_FFFF, "R2");
        drive(1'b0, 1'b1, 8'h96, 8'hF0, 4'h3, 4'hC);
        tick("R2", 1'b1);

        // R3/R4 stacked, lower page then upper page
        drive(1'b1, 1'b0, 8'h00, 8'h00, 4'h1, 4'hE);
        wr_cfg(32'h4000_0000, "R3");
        drive(1'b0, 1'b0, 8'h7E, 8'h0F, 4'h1, 4'hE);
        tick("R4", 1'b1);
        drive(1'b0, 1'b1, 8'h7E, 8'h0F, 4'h1, 4'hE);
        tick("R10", 1'b1);                      // R10: phase ignored in stacked
        m_cs_n = 1'b1;
        wr_cfg(32'h5000_0000, "R3");
        drive(1'b0, 1'b0, 8'hC3, 8'h0A, 4'h2, 4'hD);
        tick("R3", 1'b1);
        tick("R4", 1'b1);

        // R5..R8 parallel
        m_cs_n = 1'b1;
        wr_cfg(32'h6000_0000, "R5");
        drive(1'b0, 1'b0, 8'hB4, 8'h0F, 4'h5, 4'hA);
        tick("R6", 1'b1);
        drive(1'b0, 1'b1, 8'hB4, 8'hAA, 4'h5, 4'hA);
        tick("R7", 1'b1);
        drive(1'b0, 1'b1, 8'h00, 8'h00, 4'hC, 4'h3);
        tick("R8", 1'b1);

        // R9: held during transfer, overwritten, released on idle edge
        drive(1'b0, 1'b1, 8'h69, 8'hFF, 4'h6, 4'h9);
        wr_cfg(32'h4000_0000, "R9");
        tick("R9", 1'b1);
        wr_cfg(32'h5000_0000, "R9");
        tick("R9", 1'b1);                       // still parallel
        m_cs_n = 1'b1;
        tick("R9", 1'b1);                       // release edge
        drive(1'b0, 1'b0, 8'h0F, 8'h0F, 4'h4, 4'hB);
        tick("R9", 1'b1);                       // stacked, upper page

        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0] & r[1] ? 1'b1 : (r[2] & r[3] & r[4]), r[5],
                  8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom));
            m_sclk = r[6];
            if (r[10:7] == 4'd0) begin
                cfg_wr = 1'b1; cfg_wdata = $urandom;
            end
            if (!mdl_cfg[2])      tag = "R2";
            else if (!mdl_cfg[1]) tag = "R3";
            else if (m_data_phase) tag = "R7";
            else                  tag = "R6";
            if (cfg_wr && !m_cs_n) tag = "R9";
            tick(tag, 1'b1);
        end
        finish_run();
    end

endmodule